// File: doc/BRIEF.md
# Scatter/Gather Bus-Master DMA Engine

This block moves 16-bit words between a disk drive's data port and system memory without processor involvement. Software sets up an 8-byte register window: a command byte, a status byte and a 32-bit pointer to a descriptor table in memory. Each 8-byte descriptor in that table names a physical buffer and a byte count, and one flag marks the last entry. After the start bit is written, the engine reads descriptors one after another and streams data through each buffer in the chosen direction. When the last buffer is drained it raises an interrupt.

Memory is reached over a request/grant bus. The engine holds `mem_req` and the address until a one-cycle `mem_gnt`, which may carry an error. The drive side is a request/acknowledge pair. `drv_ack` is a single-cycle pulse, given only while `drv_req` is high, and one 16-bit word moves with each pulse. Register writes take effect on the clock edge. Reads return data combinationally for the presented offset.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, all three registers read as zero, `irq` is low, and neither `mem_req` nor `drv_ack` is asserted.
- R2: The window has three offsets. Offset 0 is the command byte: bit 0 is run and bit 3 is direction. Offset 2 is the status byte: bit 0 busy, bit 1 error, bit 2 interrupt, and bits 6:5 are plain software flags. Offset 4 is the table pointer, and its bits 1:0 always read 0.
- R3: Writing command bit 0 as 1 while it holds 0 and the engine is idle sets busy at once. The engine then reads the descriptor as two 32-bit words at pointer and pointer+4. In the first word, bits 31:1 give the buffer address. In the second word, bits 15:0 give the byte count and bit 31 is the last flag.
- R4: With direction 1, each word taken from the drive is written to memory at ascending consecutive 2-byte addresses. With direction 0, each word is read from memory in the same order and handed to the drive.
- R5: Each drive handshake consumes 2 bytes, so a region of N bytes takes exactly N/2 handshakes. A count field of 0 means 65536 bytes.
- R6: After a region that is not last, the next descriptor is read at pointer+8. After the last region, busy clears and the interrupt sets, so status bits 2:0 read 3'b100.
- R7: In the status byte, writing a 1 to bit 1 or bit 2 clears that bit. Bits 6:5 take the written value. Bit 0 cannot be written. Writing 0x26 therefore leaves bit 5 set and clears bits 2 and 1.
- R8: If the engine sets the interrupt in the same cycle that software writes 1 to clear it, the interrupt stays set.
- R9: Writing command bit 0 as 0 during a transfer stops it at once. Busy clears, no interrupt is raised, and no further memory or drive activity follows.
- R10: A grant carrying an error sets status bits 1 and 2 and clears busy. The failed write leaves memory unchanged, and no more words move.
- R11: While busy, writes to the direction bit are ignored.
- R12: `drv_ack` is only asserted while `drv_req` is high. Once raised, `mem_req` stays high with a stable address until granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (word in bits 15:0) |
| mem_gnt | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with `mem_gnt` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_gnt` |
| drv_req | input | 1 | Drive ready to move a word |
| drv_ack | output | 1 | Word handshake |
| drv_rdata | input | 16 | Word from the drive |
| drv_wdata | output | 16 | Word to the drive |
| irq | output | 1 | Interrupt, mirrors status bit 2 |

## Verification
The engine's own completion path sets the interrupt, and a software write to the status byte clears it, so the two can fall in the same cycle. The bench provokes this from its memory model. When it grants the final memory write of a transfer, it injects a status write of 0x26 in that same cycle. The status must then read 0x24 with `irq` still high, which shows that the set wins over the clear. A stop command racing a grant is also covered, by aborting an open-ended transfer while memory traffic is in flight.

// File: rtl/bmdma_engine.sv
module bmdma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        drv_req,
  output logic        drv_ack,
  input  logic [15:0] drv_rdata,
  output logic [15:0] drv_wdata,
  output logic        irq
);

  typedef enum logic [2:0] {S_IDLE, S_DA, S_DC, S_MEM, S_DRV} state_t;

  state_t      st;
  logic        go_q, dir_q, err_q, irq_q, last_q;
  logic [1:0]  cap_q;
  logic [31:2] base_q, ptr_q;
  logic [31:1] addr_q;
  logic [16:0] cnt_q;
  logic [15:0] buf_q;

  wire cmd_wr  = reg_wr && reg_addr == 3'd0;
  wire sts_wr  = reg_wr && reg_addr == 3'd2;
  wire base_wr = reg_wr && reg_addr == 3'd4;
  wire busy    = st != S_IDLE;
  wire abort   = cmd_wr && !reg_wdata[0];
  wire start   = cmd_wr && reg_wdata[0] && !go_q && !busy;
  wire bus_ok  = mem_req && mem_gnt && !mem_err;
  wire bus_bad = mem_req && mem_gnt && mem_err;
  wire step    = (st == S_MEM && bus_ok && dir_q) || (st == S_DRV && drv_ack && !dir_q);
  wire reg_end = step && cnt_q <= 17'd2;
  wire done    = reg_end && last_q;

  assign mem_req   = st == S_DA || st == S_DC || st == S_MEM;
  assign mem_we    = st == S_MEM && dir_q;
  assign mem_wdata = {16'h0000, buf_q};
  assign drv_ack   = st == S_DRV && drv_req;
  assign drv_wdata = buf_q;
  assign irq       = irq_q;

  always_comb begin
    case (st)
      S_DA:    mem_addr = {ptr_q, 2'b00};
      S_DC:    mem_addr = {ptr_q + 30'd1, 2'b00};
      default: mem_addr = {addr_q, 1'b0};
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {24'h0, 4'h0, dir_q, 2'b00, go_q};
      3'd2:    reg_rdata = {24'h0, 1'b0, cap_q, 2'b00, irq_q, err_q, busy};
      3'd4:    reg_rdata = {base_q, 2'b00};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      last_q <= 1'b0;
      cap_q  <= 2'b00;
      base_q <= '0;
      ptr_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
    end else begin
      if (cmd_wr) begin
        go_q <= reg_wdata[0];
        if (!busy) dir_q <= reg_wdata[3];
      end
      if (base_wr) base_q <= reg_wdata[31:2];
      if (sts_wr) begin
        cap_q <= reg_wdata[6:5];
        if (reg_wdata[1]) err_q <= 1'b0;
        if (reg_wdata[2]) irq_q <= 1'b0;
      end
      if (bus_bad && !abort) begin
        err_q <= 1'b1;
        irq_q <= 1'b1;
      end
      if (done && !abort) irq_q <= 1'b1;

      if (abort) st <= S_IDLE;
      else if (start) begin
        st    <= S_DA;
        ptr_q <= base_q;
      end else if (bus_bad) st <= S_IDLE;
      else begin
        case (st)
          S_DA: if (bus_ok) begin
            addr_q <= mem_rdata[31:1];
            st     <= S_DC;
          end
          S_DC: if (bus_ok) begin
            cnt_q  <= {mem_rdata[15:0] == 16'h0, mem_rdata[15:0]};
            last_q <= mem_rdata[31];
            st     <= dir_q ? S_DRV : S_MEM;
          end
          S_MEM: if (bus_ok && !dir_q) begin
            buf_q <= mem_rdata[15:0];
            st    <= S_DRV;
          end
          S_DRV: if (drv_ack && dir_q) begin
            buf_q <= drv_rdata;
            st    <= S_MEM;
          end
          default: ;
        endcase
        if (step) begin
          addr_q <= addr_q + 31'd1;
          cnt_q  <= cnt_q - 17'd2;
          if (reg_end) begin
            if (last_q) st <= S_IDLE;
            else begin
              ptr_q <= ptr_q + 30'd2;
              st    <= S_DA;
            end
          end else st <= dir_q ? S_DRV : S_MEM;
        end
      end
    end
  end

endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_gnt,
  input logic        mem_err,
  input logic        drv_req,
  input logic        drv_ack,
  input logic        irq,
  input logic        busy,
  input logic        err_flag
);

  wire stop_wr = reg_wr && reg_addr == 3'd0 && !reg_wdata[0];

  assert_ack_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ack |-> drv_req);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !stop_wr |=> mem_req && $stable(mem_addr));

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !drv_ack);

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !busy);

  assert_irq_from_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));

  assert_err_from_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(mem_gnt && mem_err));

endmodule

bind bmdma_engine bmdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_err(mem_err),
  .drv_req(drv_req), .drv_ack(drv_ack), .irq(irq), .busy(busy), .err_flag(err_q)
);

// File: tb/sim_bmdma_engine.sv
module sim_bmdma_engine;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        t_wr = 1'b0;
  logic [2:0]  t_addr = 3'd0;
  logic [31:0] t_wdata = 32'h0;
  logic        auto_wr = 1'b0;
  wire         reg_wr    = t_wr | auto_wr;
  wire [2:0]   reg_addr  = auto_wr ? 3'd2 : t_addr;
  wire [31:0]  reg_wdata = auto_wr ? 32'h26 : t_wdata;
  logic [31:0] reg_rdata;

  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        gnt_r = 1'b0, err_r = 1'b0;
  logic [31:0] rd_r = 32'h0;

  logic        drv_en = 1'b0;
  logic [1:0]  gap = 2'd0;
  wire         drv_req = drv_en && gap != 2'd3;
  logic        drv_ack;
  logic [15:0] drv_wdata;
  int          drv_idx = 0;
  wire [15:0]  drv_rdata = {4'hA, drv_idx[11:0]};
  logic        irq;

  logic [15:0] mem16 [0:4095];
  logic [15:0] dlog  [0:4095];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = 32'h0;
  logic [15:0] bd_data = 16'h0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = 32'h0;
  logic        arm = 1'b0;
  logic [31:0] arm_addr = 32'h0;

  int checks = 0, failures = 0;
  int bad_ack = 0, bad_hold = 0;
  logic        p_req = 1'b0, p_gnt = 1'b0, p_stop = 1'b0;
  logic [31:0] p_addr = 32'h0;

  bmdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(gnt_r), .mem_err(err_r), .mem_rdata(rd_r),
    .drv_req(drv_req), .drv_ack(drv_ack), .drv_rdata(drv_rdata), .drv_wdata(drv_wdata), .irq(irq)
  );

  always @(posedge clk) begin
    gap <= gap + 2'd1;
    if (bd_we) mem16[bd_addr[12:1]] <= bd_data;
    if (mem_req && !gnt_r) begin
      gnt_r <= 1'b1;
      err_r <= err_en && mem_addr == err_addr;
      rd_r  <= {mem16[mem_addr[12:1] | 12'd1], mem16[mem_addr[12:1]]};
      if (mem_we && !(err_en && mem_addr == err_addr)) mem16[mem_addr[12:1]] <= mem_wdata[15:0];
      auto_wr <= arm && mem_we && mem_addr == arm_addr;
    end else begin
      gnt_r <= 1'b0;
      err_r <= 1'b0;
      auto_wr <= 1'b0;
    end
    if (drv_ack) begin
      dlog[drv_idx[11:0]] <= drv_wdata;
      drv_idx <= drv_idx + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (drv_ack && !drv_req) bad_ack <= bad_ack + 1;
      if (p_req && !p_gnt && !p_stop && (!mem_req || mem_addr != p_addr)) bad_hold <= bad_hold + 1;
    end
    p_req  <= mem_req;
    p_gnt  <= gnt_r;
    p_addr <= mem_addr;
    p_stop <= reg_wr && reg_addr == 3'd0 && !reg_wdata[0];
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); t_wr = 1'b1; t_addr = a; t_wdata = d;
    @(negedge clk); t_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); t_addr = a; #1; d = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] a, input logic [15:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic desc(input logic [31:0] at, input logic [31:0] b, input logic [15:0] n, input logic last);
    poke(at, b[15:0]); poke(at + 2, b[31:16]);
    poke(at + 4, n);   poke(at + 6, {last, 15'h0});
  endtask

  task automatic go(input logic dir);
    wr(3'd0, 32'h0);
    wr(3'd0, dir ? 32'h9 : 32'h1);
  endtask

  task automatic wait_idle(input string r);
    logic [31:0] s;
    int n = 0;
    do begin rd(3'd2, s); n++; end while (s[0] && n < 20000);
    chk(r, {31'h0, s[0]}, 32'h0);
  endtask

  function automatic logic [15:0] dw(input int i);
    return 16'hA000 | 16'(i & 12'hFFF);
  endfunction

  initial begin
    #(CLK_NS * 150000);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, v); chk("R1 cmd", v, 32'h0);
    rd(3'd2, v); chk("R1 status", v, 32'h0);
    rd(3'd4, v); chk("R1 base", v, 32'h0);
    chk("R1 irq/req/ack", {irq, mem_req, drv_ack}, 32'h0);

    wr(3'd4, 32'h0000_0107); rd(3'd4, v); chk("R2 base low bits", v, 32'h104);
    wr(3'd2, 32'h60); rd(3'd2, v); chk("R2 status flags", v, 32'h60);
    wr(3'd2, 32'h00); rd(3'd2, v); chk("R2 status flags clear", v, 32'h0);
    wr(3'd0, 32'h08); rd(3'd0, v); chk("R2 cmd dir bit", v, 32'h08);

    wr(3'd4, 32'h300);
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 1; n <= 8; n++) begin
        logic [31:0] b;
        b = 32'h1000 + 32'(n) * 32'h40 + 32'(dir) * 32'h400;
        desc(32'h300, b, 16'(2 * n), 1'b1);
        for (int i = 0; i < n; i++) poke(b + 32'(2 * i), 16'h5000 + 16'(n * 16 + i));
        s0 = drv_idx;
        drv_en = 1'b1;
        go(dir[0]);
        rd(3'd2, v); chk("R3 busy after start", {31'h0, v[0]}, 32'h1);
        wait_idle("R6 sweep completes");
        drv_en = 1'b0;
        rd(3'd2, v); chk("R6 sweep status", v, 32'h04);
        chk("R5 handshake count", 32'(drv_idx - s0), 32'(n));
        for (int i = 0; i < n; i++) begin
          if (dir == 1) chk("R4 drive to memory", {16'h0, mem16[b[12:1] + 12'(i)]}, {16'h0, dw(s0 + i)});
          else chk("R4 memory to drive", {16'h0, dlog[12'(s0 + i)]}, {16'h0, 16'h5000 + 16'(n * 16 + i)});
        end
        wr(3'd2, 32'h06);
      end
    end

    wr(3'd4, 32'h100);
    desc(32'h100, 32'h1800, 16'd6, 1'b0);
    desc(32'h108, 32'h1900, 16'd4, 1'b1);
    poke(32'h1806, 16'hDEAD); poke(32'h1904, 16'hDEAD);
    s0 = drv_idx; drv_en = 1'b1;
    go(1'b1);
    wait_idle("R6 chain completes");
    drv_en = 1'b0;
    for (int i = 0; i < 3; i++) chk("R6 chain region 0", {16'h0, mem16[12'h C00 + 12'(i)]}, {16'h0, dw(s0 + i)});
    for (int i = 0; i < 2; i++) chk("R6 chain region 1", {16'h0, mem16[12'hC80 + 12'(i)]}, {16'h0, dw(s0 + 3 + i)});
    chk("R6 region 0 bound", {16'h0, mem16[12'hC03]}, 32'hDEAD);
    chk("R6 region 1 bound", {16'h0, mem16[12'hC82]}, 32'hDEAD);
    rd(3'd2, v); chk("R6 good status", v, 32'h04);
    chk("R6 irq pin", {31'h0, irq}, 32'h1);

    wr(3'd2, 32'h26); rd(3'd2, v); chk("R7 clear with 0x26", v, 32'h20);
    chk("R7 irq pin low", {31'h0, irq}, 32'h0);
    wr(3'd2, 32'h21); rd(3'd2, v); chk("R7 busy not writable", v, 32'h20);

    desc(32'h100, 32'h1A00, 16'd4, 1'b1);
    arm_addr = 32'h1A02; arm = 1'b1; drv_en = 1'b1;
    go(1'b1);
    wait_idle("R8 run completes");
    drv_en = 1'b0; arm = 1'b0;
    rd(3'd2, v); chk("R8 set beats clear", v, 32'h24);
    chk("R8 irq pin held", {31'h0, irq}, 32'h1);
    wr(3'd2, 32'h26);

    desc(32'h100, 32'h1B00, 16'd6, 1'b1);
    poke(32'h1B02, 16'hDEAD);
    err_en = 1'b1; err_addr = 32'h1B02;
    s0 = drv_idx; drv_en = 1'b1;
    go(1'b1);
    wait_idle("R10 error ends run");
    repeat (10) @(negedge clk);
    drv_en = 1'b0; err_en = 1'b0;
    rd(3'd2, v); chk("R10 error status", v, 32'h26);
    chk("R10 irq pin", {31'h0, irq}, 32'h1);
    chk("R10 first word stored", {16'h0, mem16[12'hD80]}, {16'h0, dw(s0)});
    chk("R10 failed write dropped", {16'h0, mem16[12'hD81]}, 32'hDEAD);
    chk("R10 no further words", 32'(drv_idx - s0), 32'd2);
    wr(3'd2, 32'h26); rd(3'd2, v); chk("R7 error cleared", v, 32'h20);

    begin
      int n = 0, rel, s1;
      desc(32'h100, 32'h4000, 16'd0, 1'b1);
      s0 = drv_idx; drv_en = 1'b1;
      go(1'b1);
      while (drv_idx - s0 < 100 && n < 5000) begin @(negedge clk); n++; end
      rd(3'd2, v); chk("R5 zero count still busy", {31'h0, v[0]}, 32'h1);
      wr(3'd0, 32'h1);
      rd(3'd0, v); chk("R11 dir write ignored", v, 32'h09);
      rel = drv_idx - s0;
      n = 0;
      while (drv_idx - s0 < rel + 6 && n < 5000) begin @(negedge clk); n++; end
      chk("R11 direction kept", {16'h0, mem16[12'(rel)]}, {16'h0, dw(s0 + rel)});
      wr(3'd0, 32'h0);
      rd(3'd2, v); chk("R9 abort status", v, 32'h20);
      chk("R9 no irq", {31'h0, irq}, 32'h0);
      s1 = drv_idx;
      repeat (20) @(negedge clk);
      chk("R9 no more handshakes", 32'(drv_idx - s1), 32'h0);
      chk("R9 memory quiet", {31'h0, mem_req}, 32'h0);
      drv_en = 1'b0;
    end

    chk("R12 ack only with req", 32'(bad_ack), 32'h0);
    chk("R12 request held until grant", 32'(bad_hold), 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule